// File: doc/BRIEF.md
# Coarse-Fine Hit Timestamp Channel

This block stamps asynchronous hit events with a timestamp in two parts. A free-running cycle counter supplies the coarse part. A thermometer snapshot of a tapped delay line, captured on the same reference clock, supplies the fine part. The arrival time then works out as coarse count × clock period − fine time. The fine time is the interval from the hit to the next rising clock edge, and it grows with the number of taps the hit has flipped. At the intended 400 MHz reference, one coarse step is 2.5 ns. The delay line itself is outside the block. The block chooses which trigger drives that line: either one trigger shared by all channels (evaluation use) or this channel's own trigger (measurement use). It then takes back the sampled tap vector.

The tap vector first passes through a second register stage, which acts as the metastability synchroniser. The first tap of the synchronised vector is then compared against the line's idle level. A controller state machine accepts a hit only in state `ST_ARMED`. When it accepts a hit, it registers the coarse count of the sampling cycle and a bubble-corrected fine code, and it pulses `valid_o`. It then spends one recovery cycle in `ST_RECOVER`, so the dead time is two cycles in total. The named transitions are: `ST_INIT -> ST_ARMED` (always, on the first cycle after reset), `ST_ARMED -> ST_RECOVER` (hit accepted), `ST_ARMED -> ST_ARMED` (no hit), and `ST_RECOVER -> ST_ARMED` (always). A hit seen in `ST_RECOVER` is discarded and counted in a saturating counter. A parameter selects the idle level of the line, for a rising or a falling hit transition. Calibration of the fine code happens downstream.

Top module: `hit_stamp_channel`

## Requirements
- R1: While reset is asserted, `valid_o`, `coarse_o`, `fine_o` and `drop_cnt_o` are all zero.
- R2: `hit_line_o` follows `own_trig_i` when `mode_meas_i` is 1, and follows `shared_trig_i` when it is 0.
- R3: The coarse counter starts at 0 in the first cycle after reset, increments on every clock edge and wraps modulo 2^CW. `coarse_o` reports the counter value of the cycle that ends with the tap-sampling edge.
- R4: For a clean thermometer pattern with taps 0..k-1 away from idle (1 ≤ k ≤ TAPS), `fine_o` equals k.
- R5: Bubbles are corrected. `fine_o` is i+1, where i is the highest tap that is away from idle while taps i+1 and i+2 are idle (taps past the end count as idle).
- R6: A fully flipped line gives `fine_o` = TAPS. The fine code never exceeds TAPS.
- R7: `valid_o` is high for exactly one cycle. It rises in the cycle that follows the second clock edge after the tap-sampling edge.
- R8: A hit sample that directly follows an accepted one falls in the recovery cycle, is ignored and gives no `valid_o`. The next sample after that can be accepted, so at most one hit is accepted every two cycles.
- R9: Each ignored hit increments `drop_cnt_o` by one. The counter holds at 2^DROP_W−1.
- R10: With IDLE_LVL = 1, the line idles at all ones and a hit is a falling transition. The fine code counts the taps that are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the counter, tap sampling and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_meas_i | input | 1 | 1: own trigger drives the line; 0: shared trigger drives it |
| own_trig_i | input | 1 | This channel's own trigger |
| shared_trig_i | input | 1 | Trigger shared by all channels |
| hit_line_o | output | 1 | Selected trigger, sent to the delay-line input |
| taps_i | input | TAPS | Tap states of the delay line |
| coarse_o | output | CW | Coarse count latched with the hit |
| fine_o | output | $clog2(TAPS+1) | Number of taps flipped by the hit |
| valid_o | output | 1 | One-cycle strobe marking a new timestamp |
| drop_cnt_o | output | DROP_W | Saturating count of hits ignored during dead time |

## Verification
The properties assume three things: a new hit appears in the tap vector for a single sampled cycle, the line returns to its idle level in the following cycle, and the taps form a thermometer pattern with at most small bubbles. The stimulus respects this by holding each hit pattern for exactly one sampling cycle before returning the taps to idle. Back-to-back dead-time tests place distinct patterns in adjacent cycles rather than stretching a single pulse. Triggers are checked only at the mux output, because no behavioural line links them to the taps.

// File: rtl/hts_pkg.sv
package hts_pkg;

    typedef enum logic [1:0] {
        ST_INIT    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RECOVER = 2'd2
    } hts_state_e;

endpackage

// File: rtl/hts_sampler.sv
module hts_sampler #(
    parameter int TAPS     = 64,
    parameter int CW       = 32,
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TAPS-1:0] taps_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [TAPS-1:0] sync_taps_o,
    output logic [CW-1:0]   sync_cnt_o
);
    localparam logic [TAPS-1:0] IDLE_WORD = {TAPS{IDLE_LVL}};

    logic [TAPS-1:0] cap_taps_q;
    logic [CW-1:0]   cap_cnt_q;

    // stage 1: capture flops, stage 2: metastability settling flops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_taps_q  <= IDLE_WORD;
            cap_cnt_q   <= '0;
            sync_taps_o <= IDLE_WORD;
            sync_cnt_o  <= '0;
        end else begin
            cap_taps_q  <= taps_i;
            cap_cnt_q   <= cnt_i;
            sync_taps_o <= cap_taps_q;
            sync_cnt_o  <= cap_cnt_q;
        end
    end
endmodule

// File: rtl/hts_therm_enc.sv
module hts_therm_enc #(
    parameter int TAPS = 64,
    parameter int FW   = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0] therm_i,
    output logic [FW-1:0]   fine_o
);
    logic [TAPS-1:0] edge_v;

    // an edge is an active tap followed by two idle ones (bubble filter)
    for (genvar gi = 0; gi < TAPS; gi++) begin : g_edge
        if (gi + 2 < TAPS) begin : g_full
            assign edge_v[gi] = therm_i[gi] & ~therm_i[gi+1] & ~therm_i[gi+2];
        end else if (gi + 1 < TAPS) begin : g_near
            assign edge_v[gi] = therm_i[gi] & ~therm_i[gi+1];
        end else begin : g_last
            assign edge_v[gi] = therm_i[gi];
        end
    end

    always_comb begin
        fine_o = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (edge_v[i]) fine_o = FW'(i + 1);
        end
    end
endmodule

// File: rtl/hts_ctrl.sv
module hts_ctrl
    import hts_pkg::*;
#(
    parameter int CW     = 32,
    parameter int FW     = 7,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [FW-1:0]     fine_i,
    input  logic [CW-1:0]     cnt_i,
    output logic              valid_o,
    output logic [CW-1:0]     coarse_o,
    output logic [FW-1:0]     fine_o,
    output logic [DROP_W-1:0] drop_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    hts_state_e state_q, state_d;
    logic       take_hit, lose_hit;

    assign take_hit = (state_q == ST_ARMED) && hit_i;
    assign lose_hit = (state_q == ST_RECOVER) && hit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:    state_d = ST_ARMED;
            ST_ARMED:   state_d = hit_i ? ST_RECOVER : ST_ARMED;
            ST_RECOVER: state_d = ST_ARMED;
            default:    state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            coarse_o <= '0;
            fine_o   <= '0;
            drop_o   <= '0;
        end else begin
            valid_o <= take_hit;
            if (take_hit) begin
                coarse_o <= cnt_i;
                fine_o   <= fine_i;
            end
            if (lose_hit && drop_o != DROP_MAX) drop_o <= drop_o + 1'b1;
        end
    end
endmodule

// File: rtl/hit_stamp_channel.sv
module hit_stamp_channel #(
    parameter int TAPS     = 64,
    parameter int CW       = 32,
    parameter int DROP_W   = 8,
    parameter bit IDLE_LVL = 1'b0,
    localparam int FW      = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_meas_i,
    input  logic              own_trig_i,
    input  logic              shared_trig_i,
    output logic              hit_line_o,
    input  logic [TAPS-1:0]   taps_i,
    output logic [CW-1:0]     coarse_o,
    output logic [FW-1:0]     fine_o,
    output logic              valid_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    logic [CW-1:0]   cnt_q;
    logic [TAPS-1:0] sync_taps;
    logic [CW-1:0]   sync_cnt;
    logic [TAPS-1:0] norm_taps;
    logic [FW-1:0]   enc_fine;

    assign hit_line_o = mode_meas_i ? own_trig_i : shared_trig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    hts_sampler #(.TAPS(TAPS), .CW(CW), .IDLE_LVL(IDLE_LVL)) u_samp (
        .clk(clk), .rst_n(rst_n), .taps_i(taps_i), .cnt_i(cnt_q),
        .sync_taps_o(sync_taps), .sync_cnt_o(sync_cnt)
    );

    if (IDLE_LVL) begin : g_fall
        assign norm_taps = ~sync_taps;
    end else begin : g_rise
        assign norm_taps = sync_taps;
    end

    hts_therm_enc #(.TAPS(TAPS), .FW(FW)) u_enc (
        .therm_i(norm_taps), .fine_o(enc_fine)
    );

    hts_ctrl #(.CW(CW), .FW(FW), .DROP_W(DROP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hit_i(norm_taps[0]), .fine_i(enc_fine),
        .cnt_i(sync_cnt), .valid_o(valid_o), .coarse_o(coarse_o),
        .fine_o(fine_o), .drop_o(drop_cnt_o)
    );
endmodule

// File: rtl/hts_chk.sv
module hts_chk
    import hts_pkg::*;
#(
    parameter int TAPS   = 64,
    parameter int CW     = 32,
    parameter int FW     = 7,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic [CW-1:0]     coarse_o,
    input logic [FW-1:0]     fine_o,
    input logic [DROP_W-1:0] drop_cnt_o,
    input logic [CW-1:0]     cnt_q,
    input hts_state_e        state
);
    localparam logic [DROP_W-1:0] DMAX = {DROP_W{1'b1}};

    p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_coarse_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> coarse_o == $past(cnt_q, 3));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (fine_o >= FW'(1) && fine_o <= FW'(TAPS)));

    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |=> (state == ST_ARMED && !valid_o));

    p_drop_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt_o >= $past(drop_cnt_o));

    p_drop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o == DMAX) |=> (drop_cnt_o == DMAX));
endmodule

bind hit_stamp_channel hts_chk #(
    .TAPS(TAPS), .CW(CW), .FW(FW), .DROP_W(DROP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .coarse_o(coarse_o),
    .fine_o(fine_o), .drop_cnt_o(drop_cnt_o), .cnt_q(cnt_q),
    .state(u_ctrl.state_q)
);

// File: tb/hit_stamp_channel_test.sv
`timescale 1ns/1ps
module hit_stamp_channel_test;
    localparam int TAPS = 32;
    localparam int CW   = 8;
    localparam int DW   = 3;
    localparam int FW   = $clog2(TAPS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_meas = 1'b0, own_trig = 1'b0, shared_trig = 1'b0;
    logic hit_line, hit_line_n;
    logic [TAPS-1:0] taps = '0;
    logic [TAPS-1:0] taps_n = '1;
    logic [CW-1:0] coarse, coarse_n;
    logic [FW-1:0] fine, fine_n;
    logic valid, valid_n;
    logic [DW-1:0] drops, drops_n;
    int unsigned edge_n = 0;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    hit_stamp_channel #(.TAPS(TAPS), .CW(CW), .DROP_W(DW), .IDLE_LVL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .mode_meas_i(mode_meas), .own_trig_i(own_trig),
        .shared_trig_i(shared_trig), .hit_line_o(hit_line), .taps_i(taps),
        .coarse_o(coarse), .fine_o(fine), .valid_o(valid), .drop_cnt_o(drops)
    );

    hit_stamp_channel #(.TAPS(TAPS), .CW(CW), .DROP_W(DW), .IDLE_LVL(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .mode_meas_i(1'b0), .own_trig_i(1'b0),
        .shared_trig_i(1'b0), .hit_line_o(hit_line_n), .taps_i(taps_n),
        .coarse_o(coarse_n), .fine_o(fine_n), .valid_o(valid_n), .drop_cnt_o(drops_n)
    );

    function automatic logic [TAPS-1:0] therm(input int k);
        logic [TAPS-1:0] t = '0;
        for (int i = 0; i < k; i++) t[i] = 1'b1;
        return t;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one hit held for a single sample; checks latency, pulse width, values
    task automatic t_single(input logic [TAPS-1:0] pat, input int exp_f, input string tag);
        logic [CW-1:0] exp_c;
        taps = pat;
        exp_c = CW'(edge_n);
        @(negedge clk); taps = '0;
        check(valid == 1'b0, {tag, " R7 early"}, valid, 0);
        @(negedge clk);
        check(valid == 1'b0, {tag, " R7 early"}, valid, 0);
        @(negedge clk);
        check(valid == 1'b1, {tag, " R7 strobe"}, valid, 1);
        check(coarse == exp_c, {tag, " R3 coarse"}, coarse, exp_c);
        check(fine == FW'(exp_f), {tag, " fine"}, fine, exp_f);
        @(negedge clk);
        check(valid == 1'b0, {tag, " R7 one cycle"}, valid, 0);
    endtask

    task automatic t_reset;
        check(valid == 0 && coarse == 0 && fine == 0 && drops == 0, "R1 reset", valid, 0);
    endtask

    task automatic t_mode;
        mode_meas = 0; shared_trig = 1; own_trig = 0; #1;
        check(hit_line == 1'b1, "R2 shared", hit_line, 1);
        mode_meas = 1; #1;
        check(hit_line == 1'b0, "R2 own", hit_line, 0);
        own_trig = 1; shared_trig = 0; #1;
        check(hit_line == 1'b1, "R2 own high", hit_line, 1);
        mode_meas = 0; #1;
        check(hit_line == 1'b0, "R2 shared low", hit_line, 0);
        own_trig = 0;
    endtask

    task automatic t_dead;
        logic [DW-1:0] d0;
        d0 = drops;
        taps = therm(3);
        @(negedge clk); taps = therm(7);
        @(negedge clk); taps = therm(9);
        @(negedge clk); taps = '0;
        check(valid == 1 && fine == FW'(3), "R8 first accepted", fine, 3);
        @(negedge clk);
        check(valid == 0, "R8 second ignored", valid, 0);
        check(drops == d0 + 1'b1, "R9 drop count", drops, d0 + 1);
        @(negedge clk);
        check(valid == 1 && fine == FW'(9), "R8 third accepted", fine, 9);
        @(negedge clk);
        check(valid == 0, "R8 pulse end", valid, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 20; i++) begin
            taps = therm(4 + (i % 5));
            @(negedge clk);
        end
        taps = '0;
        repeat (5) @(negedge clk);
        check(drops == {DW{1'b1}}, "R9 saturation", drops, (1 << DW) - 1);
        t_single(therm(2), 2, "R9 after saturation");
        check(drops == {DW{1'b1}}, "R9 held", drops, (1 << DW) - 1);
    endtask

    task automatic t_inverted;
        taps_n = ~therm(6);
        @(negedge clk); taps_n = '1;
        @(negedge clk);
        @(negedge clk);
        check(valid_n == 1 && fine_n == FW'(6), "R10 falling hit", fine_n, 6);
        @(negedge clk);
        check(valid_n == 0, "R10 pulse end", valid_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mode();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_single(therm(5), 5, "R4 k5");
        t_single(therm(1), 1, "R4 k1");
        t_single(therm(20), 20, "R4 k20");
        t_single(32'h0000_000B, 4, "R5 bubble low");
        t_single(32'h0000_00DF, 8, "R5 bubble mid");
        t_single('1, TAPS, "R6 full line");
        t_dead();
        t_saturate();
        t_inverted();
        while (edge_n < 300) @(negedge clk);
        t_single(therm(11), 11, "R3 after wrap");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule